// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the command-word front end of one programmable interrupt controller in a cascaded pair. It watches a byte-wide write stream, decodes writes that land on the controller's even and odd ports, and drives the configuration and state that the surrounding interrupt logic reads: the request mask, the lowest-priority line, the slave identity, the special-mask flag, the status-read selection, the vector base, the cascade wiring and the mode bits.

An even-port write with data bit 4 set starts initialization at once, from any state. It clears the mask, resets the priority and selection flags, and arms a three-step sequence. The next three odd-port writes are taken in a fixed order as vector base, cascade wiring and mode. Once the mode write lands, the `init_done` flag rises. When no sequence is running, odd-port writes load the mask. Even-port writes with bit 4 clear and bit 3 set are read-select commands.

The write stream uses valid/ready. `wr_ready` is low while reset is asserted and during the first cycle after it. From then on it stays high, so the block never applies back-pressure. A write takes effect on the rising edge where both `wr_valid` and `wr_ready` are high. All outputs are registered and show the new value right after that edge.

Top module: `pic_init_seq`

## Requirements
- R1: During reset and just after it, the outputs are: `wr_ready`=0 (while reset is held), `irq_mask`=FFh, `slave_id`=7, `lowest_prio_line`=7, `special_mask`=0, `read_isr`=0, `vector_base`=0, `cascade_map`=0, `mode_cfg`=0, `init_done`=0 and `init_busy`=0.
- R2: An accepted write to the even port (address BASE_ADDR with bit 0 clear) with data bit 4 = 1 is an init start, in any state. After it, `irq_mask`=00h, `slave_id`=7, `lowest_prio_line`=7, `special_mask`=0, `read_isr`=0 (request register selected), `init_done`=0 and `init_busy`=1. `vector_base`, `cascade_map` and `mode_cfg` keep their values until they are rewritten.
- R3: In an init start, data bits 7:5, 3, 2, 1 and 0 have no effect. Start values 10h and FFh leave identical outputs.
- R4: The first odd-port write (address BASE_ADDR with bit 0 set) after an init start loads data bits 7:3 into `vector_base`. Data bits 2:0 are discarded.
- R5: The second odd-port write loads all 8 bits into `cascade_map`. In the slave variant (IS_SLAVE=1) it also loads data bits 2:0 into `slave_id`.
- R6: The third odd-port write loads data bits 4:0 into `mode_cfg`, sets `init_done`=1 and clears `init_busy`. `init_done` rises only on that write, and `init_done` and `init_busy` are never both 1.
- R7: An odd-port write while `init_busy`=0 loads `irq_mask` with the full data byte and changes no other output.
- R8: An even-port write with bit 4 = 0 and bit 3 = 1 is a read-select command, accepted in any state. If bit 6 = 1, `special_mask` takes bit 5. If bit 1 = 1, `read_isr` takes bit 0. An even-port write with bits 4 and 3 both 0 changes nothing.
- R9: A write with `wr_valid`=0, or to an address outside the port pair, changes no output.
- R10: An init start received in the middle of a sequence restarts it. The next odd-port write is again taken as the vector base.
- R11: From the second cycle after reset is released, `wr_ready` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept; high from the second cycle after reset |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 8 | Write data |
| irq_mask | output | 8 | Request mask, 1 = line masked |
| lowest_prio_line | output | 3 | Request line holding the lowest priority |
| slave_id | output | 3 | Slave identity |
| special_mask | output | 1 | Special mask mode flag |
| read_isr | output | 1 | Status read selection: 0 = request register, 1 = in-service register |
| vector_base | output | 5 | Vector bits 7:3 |
| cascade_map | output | 8 | Cascade wiring byte |
| mode_cfg | output | 5 | Mode bits |
| init_done | output | 1 | Initialization complete |
| init_busy | output | 1 | Sequence in progress |

## Verification
A wrong sequencer step shows at the ports on the very next cycle. The data byte lands in the wrong register: a vector value shows up in `cascade_map`, or a mask write changes `vector_base`. `init_busy` and `init_done` also change one write too early or too late. A start that fails to clear state leaves `irq_mask`, `special_mask` or `read_isr` at the old value one cycle after the even-port write. The bench compares every output after every write, so any such fault is reported at the write that caused it.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  localparam int BYTE_W     = 8;
  localparam int LINE_IDX_W = 3;
  localparam int VEC_W      = BYTE_W - LINE_IDX_W;
  localparam int MODE_W     = 5;
  localparam logic [LINE_IDX_W-1:0] LINE_LAST = '1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_INIT,
    WK_READSEL,
    WK_OPCMD,
    WK_ODD
  } wr_kind_e;

  typedef struct packed {
    logic start;
    logic vec;
    logic cas;
    logic mode;
    logic mask;
  } ld_strobe_t;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_init_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctl_bits,
  output wr_kind_e          kind
);
  localparam int PAIR_W = ADDR_W - 1;
  localparam logic [PAIR_W-1:0] PAIR_TAG = BASE_ADDR[ADDR_W-1:1];

  logic pair_hit;
  assign pair_hit = accept && (addr[ADDR_W-1:1] == PAIR_TAG);

  always_comb begin
    kind = WK_NONE;
    if (pair_hit) begin
      if (addr[0]) kind = WK_ODD;
      else if (ctl_bits[1]) kind = WK_INIT;
      else if (ctl_bits[0]) kind = WK_READSEL;
      else kind = WK_OPCMD;
    end
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wr_kind_e   kind,
  output seq_state_e state,
  output ld_strobe_t ld
);
  seq_state_e nxt;

  always_comb begin
    ld  = '0;
    nxt = state;
    case (kind)
      WK_INIT: begin
        ld.start = 1'b1;
        nxt      = SEQ_W2;
      end
      WK_ODD: begin
        case (state)
          SEQ_IDLE: ld.mask = 1'b1;
          SEQ_W2: begin
            ld.vec = 1'b1;
            nxt    = SEQ_W3;
          end
          SEQ_W3: begin
            ld.cas = 1'b1;
            nxt    = SEQ_W4;
          end
          SEQ_W4: begin
            ld.mode = 1'b1;
            nxt     = SEQ_IDLE;
          end
          default: nxt = SEQ_IDLE;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_init_pkg::*;
#(
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ld_strobe_t            ld,
  input  logic                  readsel_wr,
  input  logic [BYTE_W-1:0]     data,
  output logic [BYTE_W-1:0]     irq_mask,
  output logic [LINE_IDX_W-1:0] lowest_prio_line,
  output logic [LINE_IDX_W-1:0] slave_id,
  output logic                  special_mask,
  output logic                  read_isr,
  output logic [VEC_W-1:0]      vector_base,
  output logic [BYTE_W-1:0]     cascade_map,
  output logic [MODE_W-1:0]     mode_cfg,
  output logic                  init_done
);
  assign lowest_prio_line = LINE_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask <= '1;
    end else if (ld.start) begin
      irq_mask <= '0;
    end else if (ld.mask) begin
      irq_mask <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      special_mask <= 1'b0;
      read_isr     <= 1'b0;
    end else if (ld.start) begin
      special_mask <= 1'b0;
      read_isr     <= 1'b0;
    end else if (readsel_wr) begin
      if (data[6]) special_mask <= data[5];
      if (data[1]) read_isr     <= data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector_base <= '0;
      cascade_map <= '0;
      mode_cfg    <= '0;
    end else begin
      if (ld.vec)  vector_base <= data[BYTE_W-1:LINE_IDX_W];
      if (ld.cas)  cascade_map <= data;
      if (ld.mode) mode_cfg    <= data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        init_done <= 1'b0;
    else if (ld.start) init_done <= 1'b0;
    else if (ld.mode)  init_done <= 1'b1;
  end

  generate
    if (IS_SLAVE) begin : g_slave_id
      logic [LINE_IDX_W-1:0] id_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        id_q <= LINE_LAST;
        else if (ld.start) id_q <= LINE_LAST;
        else if (ld.cas)   id_q <= data[LINE_IDX_W-1:0];
      end
      assign slave_id = id_q;
    end else begin : g_master_id
      assign slave_id = LINE_LAST;
    end
  endgenerate
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [BYTE_W-1:0]     irq_mask,
  output logic [LINE_IDX_W-1:0] lowest_prio_line,
  output logic [LINE_IDX_W-1:0] slave_id,
  output logic                  special_mask,
  output logic                  read_isr,
  output logic [VEC_W-1:0]      vector_base,
  output logic [BYTE_W-1:0]     cascade_map,
  output logic [MODE_W-1:0]     mode_cfg,
  output logic                  init_done,
  output logic                  init_busy
);
  logic       ready_q;
  logic       accept;
  wr_kind_e   kind;
  seq_state_e state;
  ld_strobe_t ld;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready  = ready_q;
  assign accept    = wr_valid && ready_q;
  assign init_busy = (state != SEQ_IDLE);

  pic_wr_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .accept  (accept),
    .addr    (wr_addr),
    .ctl_bits(wr_data[4:3]),
    .kind    (kind)
  );

  pic_init_fsm u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .kind (kind),
    .state(state),
    .ld   (ld)
  );

  pic_cfg_regs #(
    .IS_SLAVE(IS_SLAVE)
  ) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .ld              (ld),
    .readsel_wr      (kind == WK_READSEL),
    .data            (wr_data),
    .irq_mask        (irq_mask),
    .lowest_prio_line(lowest_prio_line),
    .slave_id        (slave_id),
    .special_mask    (special_mask),
    .read_isr        (read_isr),
    .vector_base     (vector_base),
    .cascade_map     (cascade_map),
    .mode_cfg        (mode_cfg),
    .init_done       (init_done)
  );
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        irq_mask,
  input logic [2:0]        slave_id,
  input logic              special_mask,
  input logic              read_isr,
  input logic [4:0]        vector_base,
  input logic [7:0]        cascade_map,
  input logic [4:0]        mode_cfg,
  input logic              init_done,
  input logic              init_busy
);
  logic acc, in_pair, even_w, odd_w;
  assign acc     = wr_valid && wr_ready;
  assign in_pair = (wr_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign even_w  = acc && in_pair && !wr_addr[0];
  assign odd_w   = acc && in_pair && wr_addr[0];

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (even_w && wr_data[4]) |=> (irq_mask == 8'h00 && slave_id == 3'd7 && !special_mask && !read_isr && !init_done && init_busy)); // R2

  AST_DONE_AFTER_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(odd_w && init_busy)); // R6

  AST_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_busy)); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_w && !init_busy) |=> (irq_mask == $past(wr_data) && $stable(vector_base) && $stable(cascade_map) && $stable(mode_cfg))); // R7

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || !in_pair) |=> ($stable(irq_mask) && $stable(vector_base) && $stable(cascade_map) && $stable(mode_cfg) && $stable(init_busy) && $stable(special_mask) && $stable(read_isr))); // R9

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready); // R11
endmodule

bind pic_init_seq pic_init_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .irq_mask    (irq_mask),
  .slave_id    (slave_id),
  .special_mask(special_mask),
  .read_isr    (read_isr),
  .vector_base (vector_base),
  .cascade_map (cascade_map),
  .mode_cfg    (mode_cfg),
  .init_done   (init_done),
  .init_busy   (init_busy)
);

// File: tb/test_pic_init_seq.sv
module test_pic_init_seq;
  localparam logic [7:0] BASE = 8'hA0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] irq_mask;
  logic [2:0] lowest_prio_line;
  logic [2:0] slave_id;
  logic       special_mask;
  logic       read_isr;
  logic [4:0] vector_base;
  logic [7:0] cascade_map;
  logic [4:0] mode_cfg;
  logic       init_done;
  logic       init_busy;

  always #4 clk = ~clk;

  pic_init_seq #(
    .ADDR_W   (8),
    .BASE_ADDR(BASE),
    .IS_SLAVE (1'b1)
  ) i_pic_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_mask(irq_mask),
    .lowest_prio_line(lowest_prio_line), .slave_id(slave_id),
    .special_mask(special_mask), .read_isr(read_isr),
    .vector_base(vector_base), .cascade_map(cascade_map),
    .mode_cfg(mode_cfg), .init_done(init_done), .init_busy(init_busy)
  );

  typedef struct {
    string     tag;
    logic [35:0] val;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  logic [7:0] m_imr  = 8'hFF;
  logic [2:0] m_sid  = 3'd7;
  logic       m_smm  = 1'b0;
  logic       m_rsel = 1'b0;
  logic [4:0] m_vec  = '0;
  logic [7:0] m_cas  = '0;
  logic [4:0] m_mode = '0;
  logic       m_done = 1'b0;
  int         m_step = 0;

  function automatic logic [35:0] pack_model();
    return {m_imr, m_sid, m_smm, m_rsel, m_vec, m_cas, m_mode, m_done, (m_step != 0), 3'd7};
  endfunction

  function automatic logic [35:0] pack_dut();
    return {irq_mask, slave_id, special_mask, read_isr, vector_base, cascade_map,
            mode_cfg, init_done, init_busy, lowest_prio_line};
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag;
    e.val = pack_model();
    q.push_back(e);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a[7:1] == BASE[7:1]) begin
      if (!a[0]) begin
        if (d[4]) begin
          m_imr = 8'h00; m_sid = 3'd7; m_smm = 1'b0; m_rsel = 1'b0;
          m_done = 1'b0; m_step = 1;
        end else if (d[3]) begin
          if (d[6]) m_smm = d[5];
          if (d[1]) m_rsel = d[0];
        end
      end else begin
        case (m_step)
          0: m_imr = d;
          1: begin m_vec = d[7:3]; m_step = 2; end
          2: begin m_cas = d; m_sid = d[2:0]; m_step = 3; end
          default: begin m_mode = d[4:0]; m_done = 1'b1; m_step = 0; end
        endcase
      end
    end
  endtask

  task automatic wr(input logic v, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    if (v) model_write(a, d);
    push(tag);
    wr_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      logic [35:0] act;
      e = q.pop_front();
      act = pack_dut();
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.val);
      end
    end
  end

  task automatic direct(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    direct(wr_ready === 1'b0, "R1 ready low in reset", {7'd0, wr_ready}, 8'h00);
    direct(irq_mask === 8'hFF && init_done === 1'b0, "R1 reset mask", irq_mask, 8'hFF);
    rst_n = 1'b1;
    @(posedge clk); #1;
    push("R1 state after reset");
    @(negedge clk);
    direct(wr_ready === 1'b1, "R11 ready after reset", {7'd0, wr_ready}, 8'h01);

    wr(1, BASE | 8'h01, 8'h5A, "R7 mask write idle");
    wr(0, BASE | 8'h01, 8'h33, "R9 valid low ignored");
    wr(1, 8'h21, 8'h10, "R9 foreign address ignored");
    wr(1, BASE, 8'h6B, "R8 read-select sets smm and isr");
    wr(1, BASE, 8'h20, "R8 other command ignored");
    wr(1, BASE, 8'h11, "R2 init start clears");
    wr(1, BASE | 8'h01, 8'h47, "R4 vector base");
    wr(1, BASE | 8'h01, 8'h05, "R5 cascade and slave id");
    wr(1, BASE | 8'h01, 8'h1D, "R6 mode and done");
    wr(1, BASE | 8'h01, 8'hC3, "R7 mask after init");
    wr(1, BASE, 8'h6B, "R8 read-select again");
    wr(1, BASE, 8'hFF, "R3 start with all bits set");
    wr(1, BASE | 8'h01, 8'hF8, "R4 vector base low bits dropped");
    wr(1, BASE, 8'h10, "R10 restart mid sequence");
    wr(1, BASE | 8'h01, 8'h10, "R10 first odd is vector again");
    wr(1, BASE | 8'h01, 8'h02, "R5 second cascade load");
    wr(1, BASE | 8'h01, 8'h01, "R6 second completion");
    wr(1, BASE, 8'h4A, "R8 clear smm and select irr");
    wr(1, BASE | 8'h01, 8'h81, "R7 mask write after reselect");

    repeat (4) @(posedge clk);
    direct(wr_ready === 1'b1, "R11 ready held", {7'd0, wr_ready}, 8'h01);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule